// File: doc/BRIEF.md
# Reciprocal Multiply-High Unit

This block turns a division by a known constant into one pipelined operation. It takes a 32-bit register operand and a 32-bit unsigned constant and forms their full widening product. It then returns the product shifted right by 32, 33, 34 or 35 bits. A compiler that has already worked out the magic constant for a divisor can therefore replace a slow iterative divide with one issue to this unit, with no separate shift instruction afterwards.

The register operand can be read as unsigned or as two's-complement signed. The constant is always unsigned. In signed mode the shift is arithmetic, so results round toward minus infinity. The 32-bit result can be widened to a 64-bit destination. In that case a signed result is sign-extended and an unsigned result is zero-extended.

The unit takes one operation per clock and returns it exactly three clocks later. The mode, shift selection and width request travel down the pipeline with each operation, so every cycle may carry a different mix. There is no stall and no back-pressure.

Top module: `recip_mul_shift`

## Requirements
- R1: With `in_signed`=0, `out_data[31:0]` equals bits of the 64-bit unsigned product `in_opnd*in_const`, starting at bit position 32+`in_shift`.
- R2: With `in_signed`=1, `in_opnd` is two's-complement signed and `in_const` stays unsigned. The result is the low 32 bits of floor(product / 2^(32+`in_shift`)). For example, -1 times 1 with shift code 0 gives 0xFFFFFFFF.
- R3: The shift code `in_shift` selects the shift distance: 2'b00 is 32, 2'b01 is 33, 2'b10 is 34 and 2'b11 is 35 bits.
- R4: `out_valid` rises exactly 3 clock edges after the edge that samples `in_valid`=1, and `out_data` then belongs to that operation.
- R5: An operation can be issued on every clock. Back-to-back operations with different mode, shift and width settings each return their own correct result, in order.
- R6: `out_data[63:32]` is a copy of `out_data[31]` when both `in_signed`=1 and `in_wide`=1. It is zero in every other combination.
- R7: While `rst_n` is low, and for the first 3 edges after it rises, `out_valid` is 0.
- R8: A cycle with `in_valid`=0 gives `out_valid`=0 three edges later. Idle slots between operations stay idle at the output.
- R9: In unsigned mode, the following settings reproduce `x / d` exactly for every 32-bit `x`: constant 0xAAAAAAAB with shift code 01 gives division by 3; constant 0xCCCCCCCD with shift code 10 gives division by 5; the same constant with shift code 11 gives division by 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_signed | input | 1 | 1 = register operand is signed, 0 = unsigned |
| in_shift | input | 2 | Shift code, distance 32 + code |
| in_wide | input | 1 | 1 = result goes to a 64-bit destination |
| in_opnd | input | 32 | Register operand |
| in_const | input | 32 | Unsigned constant multiplier |
| out_valid | output | 1 | Result is valid this cycle |
| out_data | output | 64 | Result: low half is the shifted product, high half is the extension |

## Verification
Operands at the extremes (all ones, the top bit alone, zero) are run under every shift code. Next to them are a few hand-worked products, such as 2^31 times 16, whose fixed answers show whether each shift code picks the right distance. The same negative operand is sent in both modes and with both width settings. This shows whether the sign reaches the multiplier, whether floor rounding holds, and whether the extension follows the mode and width controls. Alternating modes issued back-to-back, and operations spaced by idle slots, show whether the controls and the valid bit stay aligned with their data. Sweeps of dividends checked against true division by 3, 5 and 10 confirm the end use.

// File: rtl/recip_mul_pkg.sv
package recip_mul_pkg;

    localparam int unsigned SHIFT_SEL_W = 2;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } sign_mode_e;

    // Control word that travels beside the data through every stage
    typedef struct packed {
        logic                   vld;
        sign_mode_e             mode;
        logic [SHIFT_SEL_W-1:0] sel;
        logic                   wide;
    } ctl_t;

endpackage

// File: rtl/rms_operand_stage.sv
module rms_operand_stage
    import recip_mul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_signed,
    input  logic [SHIFT_SEL_W-1:0] in_shift,
    input  logic                   in_wide,
    input  logic [DATA_W-1:0]      in_opnd,
    input  logic [DATA_W-1:0]      in_const,
    output ctl_t                   ctl_q,
    output logic [DATA_W:0]        a_q,
    output logic [DATA_W:0]        c_q
);

    sign_mode_e      mode_d;
    logic [DATA_W:0] a_d;

    always_comb begin
        mode_d = in_signed ? MODE_SIGNED : MODE_UNSIGNED;
        unique case (mode_d)
            MODE_SIGNED:   a_d = {in_opnd[DATA_W-1], in_opnd};
            MODE_UNSIGNED: a_d = {1'b0, in_opnd};
            default:       a_d = {1'b0, in_opnd};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q.vld  <= in_valid;
            ctl_q.mode <= mode_d;
            ctl_q.sel  <= in_shift;
            ctl_q.wide <= in_wide;
        end
    end

    always_ff @(posedge clk) begin
        a_q <= a_d;
        c_q <= {1'b0, in_const};
    end

endmodule

// File: rtl/rms_product_stage.sv
module rms_product_stage
    import recip_mul_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned PW    = 2 * DATA_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ctl_t                 ctl_i,
    input  logic [DATA_W:0]      a_i,
    input  logic [DATA_W:0]      c_i,
    output ctl_t                 ctl_q,
    output logic signed [PW-1:0] prod_q
);

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] c_ext;
    logic signed [PW-1:0] prod_d;

    always_comb begin
        a_ext  = {{(DATA_W + 1){a_i[DATA_W]}}, a_i};
        c_ext  = {{(DATA_W + 1){c_i[DATA_W]}}, c_i};
        prod_d = a_ext * c_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_i;
        end
    end

    always_ff @(posedge clk) begin
        prod_q <= prod_d;
    end

endmodule

// File: rtl/rms_select_stage.sv
module rms_select_stage
    import recip_mul_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SHIFT_BASE = 32,
    localparam int unsigned PW        = 2 * DATA_W + 2,
    localparam int unsigned AMT_W     = $clog2(SHIFT_BASE + (1 << SHIFT_SEL_W)) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  ctl_t                  ctl_i,
    input  logic signed [PW-1:0]  prod_i,
    output logic                  out_valid,
    output logic [2*DATA_W-1:0]   out_data
);

    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] lo_d;
    logic [DATA_W-1:0] hi_d;

    always_comb begin
        amt  = AMT_W'(SHIFT_BASE) + AMT_W'(ctl_i.sel);
        lo_d = DATA_W'(prod_i >>> amt);
        unique case (ctl_i.mode)
            MODE_SIGNED:   hi_d = ctl_i.wide ? {DATA_W{lo_d[DATA_W-1]}} : '0;
            MODE_UNSIGNED: hi_d = '0;
            default:       hi_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= ctl_i.vld;
        end
    end

    always_ff @(posedge clk) begin
        out_data <= {hi_d, lo_d};
    end

endmodule

// File: rtl/recip_mul_shift.sv
module recip_mul_shift
    import recip_mul_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SHIFT_BASE = 32,
    localparam int unsigned PW        = 2 * DATA_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_signed,
    input  logic [SHIFT_SEL_W-1:0] in_shift,
    input  logic                   in_wide,
    input  logic [DATA_W-1:0]      in_opnd,
    input  logic [DATA_W-1:0]      in_const,
    output logic                   out_valid,
    output logic [2*DATA_W-1:0]    out_data
);

    ctl_t                 ctl_s1;
    ctl_t                 ctl_s2;
    logic [DATA_W:0]      a_s1;
    logic [DATA_W:0]      c_s1;
    logic signed [PW-1:0] prod_s2;

    rms_operand_stage #(.DATA_W(DATA_W)) u_prep (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_signed(in_signed),
        .in_shift (in_shift),
        .in_wide  (in_wide),
        .in_opnd  (in_opnd),
        .in_const (in_const),
        .ctl_q    (ctl_s1),
        .a_q      (a_s1),
        .c_q      (c_s1)
    );

    rms_product_stage #(.DATA_W(DATA_W)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_i  (ctl_s1),
        .a_i    (a_s1),
        .c_i    (c_s1),
        .ctl_q  (ctl_s2),
        .prod_q (prod_s2)
    );

    rms_select_stage #(.DATA_W(DATA_W), .SHIFT_BASE(SHIFT_BASE)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl_s2),
        .prod_i    (prod_s2),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/recip_mul_shift_chk.sv
module recip_mul_shift_chk #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned SHIFT_BASE = 32,
    localparam int unsigned W2        = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_signed,
    input logic [1:0]        in_shift,
    input logic              in_wide,
    input logic [DATA_W-1:0] in_opnd,
    input logic [DATA_W-1:0] in_const,
    input logic              out_valid,
    input logic [W2-1:0]     out_data
);

    logic [2:0]        vd;
    logic [1:0]        cyc;
    logic              sgn_p  [3];
    logic              wide_p [3];
    logic [1:0]        sel_p  [3];
    logic [DATA_W-1:0] op_p   [3];
    logic [DATA_W-1:0] k_p    [3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd  <= '0;
            cyc <= '0;
        end else begin
            vd  <= {vd[1:0], in_valid};
            cyc <= (cyc == 2'd3) ? cyc : cyc + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        sgn_p[0]  <= in_signed;  sgn_p[1]  <= sgn_p[0];  sgn_p[2]  <= sgn_p[1];
        wide_p[0] <= in_wide;    wide_p[1] <= wide_p[0]; wide_p[2] <= wide_p[1];
        sel_p[0]  <= in_shift;   sel_p[1]  <= sel_p[0];  sel_p[2]  <= sel_p[1];
        op_p[0]   <= in_opnd;    op_p[1]   <= op_p[0];   op_p[2]   <= op_p[1];
        k_p[0]    <= in_const;   k_p[1]    <= k_p[0];    k_p[2]    <= k_p[1];
    end

    logic [W2-1:0]        ref_u;
    logic signed [W2-1:0] ref_s;
    logic [7:0]           ref_amt;
    logic [DATA_W-1:0]    exp_lo;

    always_comb begin
        ref_u   = {{DATA_W{1'b0}}, op_p[2]} * {{DATA_W{1'b0}}, k_p[2]};
        ref_s   = $signed({{DATA_W{op_p[2][DATA_W-1]}}, op_p[2]}) * $signed({{DATA_W{1'b0}}, k_p[2]});
        ref_amt = 8'(SHIFT_BASE) + 8'(sel_p[2]);
        exp_lo  = sgn_p[2] ? DATA_W'(ref_s >>> ref_amt) : DATA_W'(ref_u >> ref_amt);
    end

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd3) |-> !out_valid);

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vd[2]);

    // R1 R2 R3
    value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[DATA_W-1:0] == exp_lo));

    // R6
    extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[W2-1:DATA_W] ==
            ((sgn_p[2] && wide_p[2]) ? {DATA_W{out_data[DATA_W-1]}} : {DATA_W{1'b0}})));

endmodule

bind recip_mul_shift recip_mul_shift_chk #(.DATA_W(DATA_W), .SHIFT_BASE(SHIFT_BASE)) u_chk (.*);

// File: tb/recip_mul_shift_tb.sv
`timescale 1ns/1ps
module recip_mul_shift_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_signed = 1'b0;
    logic [1:0]  in_shift = 2'b00;
    logic        in_wide = 1'b0;
    logic [31:0] in_opnd = '0;
    logic [31:0] in_const = '0;
    logic        out_valid;
    logic [63:0] out_data;

    int checks = 0;
    int errors = 0;

    bit          ev [3];
    logic [63:0] ed [3];
    string       et [3];

    always #4 clk = ~clk;

    recip_mul_shift u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_signed(in_signed),
        .in_shift(in_shift), .in_wide(in_wide), .in_opnd(in_opnd),
        .in_const(in_const), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] model(bit sgn, bit [1:0] sh, bit wide,
                                          bit [31:0] op, bit [31:0] k);
        logic [63:0] pu;
        longint      ps;
        logic [31:0] lo;
        if (!sgn) begin
            pu = {32'b0, op} * {32'b0, k};
            lo = 32'(pu >> (32 + sh));
            return {32'b0, lo};
        end
        ps = longint'($signed(op)) * longint'({32'b0, k});
        lo = 32'(ps >>> (32 + sh));
        return wide ? {{32{lo[31]}}, lo} : {32'b0, lo};
    endfunction

    // One cycle: check the result due now, then drive the next slot
    task automatic step(bit v, bit sgn, bit [1:0] sh, bit wide, bit [31:0] op,
                        bit [31:0] k, logic [63:0] exp, string tag);
        @(negedge clk);
        chk(out_valid == ev[2], "R4 R8", "out_valid", {63'b0, out_valid}, {63'b0, ev[2]});
        if (ev[2]) chk(out_data == ed[2], et[2], "out_data", out_data, ed[2]);
        ev[2] = ev[1]; ed[2] = ed[1]; et[2] = et[1];
        ev[1] = ev[0]; ed[1] = ed[0]; et[1] = et[0];
        ev[0] = v;     ed[0] = exp;   et[0] = tag;
        in_valid = v; in_signed = sgn; in_shift = sh; in_wide = wide;
        in_opnd = op; in_const = k;
    endtask

    task automatic issue(bit sgn, bit [1:0] sh, bit wide, bit [31:0] op, bit [31:0] k, string tag);
        step(1'b1, sgn, sh, wide, op, k, model(sgn, sh, wide, op, k), tag);
    endtask

    task automatic idle(int n);
        repeat (n) step(1'b0, 1'b0, 2'b00, 1'b0, '0, '0, '0, "R8");
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7", "out_valid in reset", {63'b0, out_valid}, 64'd0);
        end
        rst_n = 1'b1;
        idle(4);
    endtask

    task automatic t_unsigned;
        for (int s = 0; s < 4; s++) begin
            issue(1'b0, 2'(s), 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
            issue(1'b0, 2'(s), 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, "R1 R6");
            issue(1'b0, 2'(s), 1'b0, 32'h0000_0000, 32'hDEAD_BEEF, "R1");
            // 2^31 * 16 = 2^35: fixed answers 8, 4, 2, 1
            step(1'b1, 1'b0, 2'(s), 1'b0, 32'h8000_0000, 32'h0000_0010,
                 64'd8 >> s, "R3");
        end
        idle(3);
    endtask

    task automatic t_signed;
        step(1'b1, 1'b1, 2'b00, 1'b1, 32'hFFFF_FFFF, 32'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R2 R6");
        step(1'b1, 1'b1, 2'b00, 1'b0, 32'hFFFF_FFFF, 32'd1, 64'h0000_0000_FFFF_FFFF, "R2 R6");
        step(1'b1, 1'b0, 2'b00, 1'b1, 32'hFFFF_FFFF, 32'd1, 64'd0, "R1 R6");
        for (int s = 0; s < 4; s++) begin
            issue(1'b1, 2'(s), 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R2 R6");
            issue(1'b1, 2'(s), 1'b1, 32'hFFFF_FFF9, 32'hAAAA_AAAB, "R2 R6");
            issue(1'b1, 2'(s), 1'b0, 32'h7FFF_FFFF, 32'hCCCC_CCCD, "R2 R6");
            issue(1'b1, 2'(s), 1'b1, 32'd100, 32'h0000_0003, "R2");
        end
        idle(3);
    endtask

    task automatic t_back_to_back;
        for (int i = 0; i < 16; i++) begin
            issue(i[0], 2'(i), i[1], 32'hF00D_0000 ^ (i * 32'h1357_9BDF),
                  32'h8765_4321 + 32'(i), "R5");
        end
        idle(3);
    endtask

    task automatic t_bubbles;
        issue(1'b0, 2'b01, 1'b0, 32'd999, 32'hAAAA_AAAB, "R8");
        idle(2);
        issue(1'b1, 2'b10, 1'b1, 32'hFFFF_0000, 32'h1234_5678, "R8");
        idle(1);
        issue(1'b0, 2'b11, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, "R8");
        idle(3);
    endtask

    task automatic t_divide;
        logic [31:0] xs [11] = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd4, 32'd5,
            32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFD, 32'hFFFF_FFFE, 32'hFFFF_FFFF};
        for (int i = 0; i < 11 + 40; i++) begin
            logic [31:0] x;
            x = (i < 11) ? xs[i] : (32'(i) * 32'h0F0F_0F0F + 32'(i * 7));
            step(1'b1, 1'b0, 2'b01, 1'b0, x, 32'hAAAA_AAAB, {32'b0, x / 32'd3}, "R9 div3");
            step(1'b1, 1'b0, 2'b10, 1'b0, x, 32'hCCCC_CCCD, {32'b0, x / 32'd5}, "R9 div5");
            step(1'b1, 1'b0, 2'b11, 1'b0, x, 32'hCCCC_CCCD, {32'b0, x / 32'd10}, "R9 div10");
        end
        idle(3);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin ev[i] = 1'b0; ed[i] = '0; et[i] = ""; end
        t_reset();
        t_unsigned();
        t_signed();
        t_back_to_back();
        t_bubbles();
        t_divide();
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule